// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a microcontroller's functions stop for power saving and when they resume. Software writes a two-bit control value through a write strobe. One bit asks for a light sleep, where the processor waits and some peripherals keep working. The other bit asks for a deep sleep, where the oscillator is switched off. The deep-sleep request only takes effect while an external enable pin is high.

The block turns the current mode into a set of registered control lines:
- a halt for the processor;
- a halt plus a hold-in-reset for the general-purpose timer;
- a reset plus a force-output-high for each pulse-width channel;
- a disable and a one-cycle abort for the analog converter;
- run enables for the peripherals that stay alive during light sleep;
- the oscillator enable.

Any enabled interrupt wakes the block from light sleep. Only reset leaves deep sleep.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, all halt, reset, abort, force-high and disable outputs are 0, `aux_run` is all ones, `osc_en` is 1, and `in_idle` and `in_pdown` are 0.
- R2: A write with `reg_wdata[0]`=1 (the idle bit) and `reg_wdata[1]`=0 asserts the following on the second rising edge after the write cycle: `cpu_halt`, `t2_halt`, `t2_rst`, every `pwm_rst` and `pwm_hold_high` bit, `adc_off` and `in_idle`. `aux_run` stays all ones and `osc_en` stays 1.
- R3: On that same edge `adc_abort` pulses for exactly one cycle, and only when `adc_busy` was high in the cycle before it and the block was running. Otherwise it stays 0.
- R4: A write with `reg_wdata[1]`=1 (the power-down bit) while `pd_enable` is high enters power-down on the second edge. All idle-class outputs are asserted, `aux_run` is all zeros, `osc_en` is 0 and `in_pdown` is 1.
- R5: A power-down write while `pd_enable` is low leaves the power-down bit clear. `osc_en` stays 1 and `in_pdown` stays 0.
- R6: In idle, an interrupt with `(irq_req & irq_mask)` nonzero clears the idle bit on the next edge, and all outputs return to the running state one edge later. A request whose mask bits are all 0 has no effect.
- R7: Once in power-down, neither interrupts nor a write of 0 to the power-down bit leave it. Only `rst` does.
- R8: When both bits are set, power-down takes priority over idle.
- R9: `cpu_halt`, `t2_halt`, `t2_rst`, `adc_off` and every `pwm_rst` and `pwm_hold_high` bit always change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 2 | Bit 0 idle request, bit 1 power-down request |
| pd_enable | input | 1 | External permission for power-down |
| irq_req | input | NUM_IRQ | Interrupt requests |
| irq_mask | input | NUM_IRQ | Interrupt enables |
| adc_busy | input | 1 | Converter has a conversion in progress |
| cpu_halt | output | 1 | Processor halted, state kept |
| t2_halt | output | 1 | General-purpose timer halted |
| t2_rst | output | 1 | General-purpose timer held in reset |
| pwm_rst | output | NUM_PWM | Pulse-width channel reset |
| pwm_hold_high | output | NUM_PWM | Pulse-width output forced high |
| adc_off | output | 1 | Converter disabled |
| adc_abort | output | 1 | One-cycle abort of a running conversion |
| aux_run | output | NUM_AUX | Run enables of the always-alive peripherals |
| osc_en | output | 1 | Oscillator enable |
| in_idle | output | 1 | Idle mode active |
| in_pdown | output | 1 | Power-down mode active |

## Verification
The properties assume a synchronous reset is applied from time zero. They also assume `reg_wr`, `reg_wdata` and `pd_enable` are stable across the cycle in which a write is sampled. The power-down check relates a rise of `in_pdown` to a permitted write two cycles earlier. That check would misfire if a write arrived within two cycles of reset release. The stimulus therefore holds a couple of idle cycles after every reset. It drives every input on the falling edge and keeps `adc_busy` constant across each entry sequence, so the abort pulse has one defined cause.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int CTL_W    = 2;
  localparam int IDLE_BIT = 0;
  localparam int PD_BIT   = 1;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_e;
endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_mode_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [CTL_W-1:0]   reg_wdata,
  input  logic               pd_enable,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_mask,
  output logic               idle_bit,
  output logic               pd_bit
);
  logic wake;
  logic pd_set;

  assign wake   = |(irq_req & irq_mask);
  assign pd_set = reg_wr && reg_wdata[PD_BIT] && pd_enable;

  // idle bit: a write wins over a wake in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_bit <= 1'b0;
    end else if (reg_wr) begin
      idle_bit <= reg_wdata[IDLE_BIT];
    end else if (wake) begin
      idle_bit <= 1'b0;
    end
  end

  // power-down bit: set only when permitted, cleared only by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_bit <= 1'b0;
    end else if (pd_set) begin
      pd_bit <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_mode_pkg::*;
(
  input  logic   idle_bit,
  input  logic   pd_bit,
  output pmode_e mode_nxt
);
  always_comb begin
    if (pd_bit) begin
      mode_nxt = MODE_PDOWN;
    end else if (idle_bit) begin
      mode_nxt = MODE_IDLE;
    end else begin
      mode_nxt = MODE_RUN;
    end
  end
endmodule

// File: rtl/pwr_out_regs.sv
module pwr_out_regs
  import pwr_mode_pkg::*;
#(
  parameter int NUM_PWM = 2,
  parameter int NUM_AUX = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  pmode_e             mode_nxt,
  input  logic               adc_busy,
  output logic               cpu_halt,
  output logic               t2_halt,
  output logic               t2_rst,
  output logic [NUM_PWM-1:0] pwm_rst,
  output logic [NUM_PWM-1:0] pwm_hold_high,
  output logic               adc_off,
  output logic               adc_abort,
  output logic [NUM_AUX-1:0] aux_run,
  output logic               osc_en,
  output logic               in_idle,
  output logic               in_pdown
);
  pmode_e mode_q;
  logic   lowp_nxt;
  logic   clk_on_nxt;
  logic   entering;

  assign lowp_nxt   = (mode_nxt != MODE_RUN);
  assign clk_on_nxt = (mode_nxt != MODE_PDOWN);
  assign entering   = lowp_nxt && (mode_q == MODE_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_RUN;
      cpu_halt  <= 1'b0;
      t2_halt   <= 1'b0;
      t2_rst    <= 1'b0;
      adc_off   <= 1'b0;
      adc_abort <= 1'b0;
      osc_en    <= 1'b1;
      aux_run   <= '1;
      in_idle   <= 1'b0;
      in_pdown  <= 1'b0;
    end else begin
      mode_q    <= mode_nxt;
      cpu_halt  <= lowp_nxt;
      t2_halt   <= lowp_nxt;
      t2_rst    <= lowp_nxt;
      adc_off   <= lowp_nxt;
      adc_abort <= entering && adc_busy;
      osc_en    <= clk_on_nxt;
      aux_run   <= {NUM_AUX{clk_on_nxt}};
      in_idle   <= (mode_nxt == MODE_IDLE);
      in_pdown  <= (mode_nxt == MODE_PDOWN);
    end
  end

  for (genvar ch = 0; ch < NUM_PWM; ch++) begin : g_pwm
    always_ff @(posedge clk) begin
      if (rst) begin
        pwm_rst[ch]       <= 1'b0;
        pwm_hold_high[ch] <= 1'b0;
      end else begin
        pwm_rst[ch]       <= lowp_nxt;
        pwm_hold_high[ch] <= lowp_nxt;
      end
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int NUM_PWM = 2,
  parameter int NUM_AUX = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [CTL_W-1:0]   reg_wdata,
  input  logic               pd_enable,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               adc_busy,
  output logic               cpu_halt,
  output logic               t2_halt,
  output logic               t2_rst,
  output logic [NUM_PWM-1:0] pwm_rst,
  output logic [NUM_PWM-1:0] pwm_hold_high,
  output logic               adc_off,
  output logic               adc_abort,
  output logic [NUM_AUX-1:0] aux_run,
  output logic               osc_en,
  output logic               in_idle,
  output logic               in_pdown
);
  logic   idle_bit;
  logic   pd_bit;
  pmode_e mode_nxt;

  pwr_ctl_reg #(.NUM_IRQ(NUM_IRQ)) u_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .pd_enable(pd_enable), .irq_req(irq_req), .irq_mask(irq_mask),
    .idle_bit(idle_bit), .pd_bit(pd_bit)
  );

  pwr_mode_decode u_dec (
    .idle_bit(idle_bit), .pd_bit(pd_bit), .mode_nxt(mode_nxt)
  );

  pwr_out_regs #(.NUM_PWM(NUM_PWM), .NUM_AUX(NUM_AUX)) u_out (
    .clk(clk), .rst(rst), .mode_nxt(mode_nxt), .adc_busy(adc_busy),
    .cpu_halt(cpu_halt), .t2_halt(t2_halt), .t2_rst(t2_rst),
    .pwm_rst(pwm_rst), .pwm_hold_high(pwm_hold_high),
    .adc_off(adc_off), .adc_abort(adc_abort), .aux_run(aux_run),
    .osc_en(osc_en), .in_idle(in_idle), .in_pdown(in_pdown)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NUM_PWM = 2,
  parameter int NUM_AUX = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [1:0]         reg_wdata,
  input logic               pd_enable,
  input logic               cpu_halt,
  input logic               t2_halt,
  input logic               t2_rst,
  input logic [NUM_PWM-1:0] pwm_rst,
  input logic [NUM_PWM-1:0] pwm_hold_high,
  input logic               adc_off,
  input logic               adc_abort,
  input logic [NUM_AUX-1:0] aux_run,
  input logic               osc_en,
  input logic               in_pdown
);
  AST_GROUP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (t2_halt == cpu_halt) && (t2_rst == cpu_halt) && (adc_off == cpu_halt) &&
    (pwm_rst == {NUM_PWM{cpu_halt}}) && (pwm_hold_high == {NUM_PWM{cpu_halt}})); // R9

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    adc_abort |=> !adc_abort); // R3

  AST_ABORT_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    adc_abort |-> $rose(cpu_halt)); // R3

  AST_PDOWN_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
    in_pdown |-> (!osc_en && (aux_run == '0) && cpu_halt)); // R4

  AST_PDOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
    in_pdown |=> in_pdown); // R7

  AST_PDOWN_PERMITTED: assert property (@(posedge clk) disable iff (rst)
    $rose(in_pdown) |-> $past(reg_wr && reg_wdata[1] && pd_enable, 2)); // R5
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_PWM(NUM_PWM), .NUM_AUX(NUM_AUX)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .pd_enable(pd_enable), .cpu_halt(cpu_halt), .t2_halt(t2_halt),
  .t2_rst(t2_rst), .pwm_rst(pwm_rst), .pwm_hold_high(pwm_hold_high),
  .adc_off(adc_off), .adc_abort(adc_abort), .aux_run(aux_run),
  .osc_en(osc_en), .in_pdown(in_pdown)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int NI = 4;
  localparam int NP = 2;
  localparam int NA = 6;
  localparam int VW = 3 + 2*NP + 2 + NA + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_wdata = '0;
  logic pd_enable = 1'b0;
  logic [NI-1:0] irq_req = '0;
  logic [NI-1:0] irq_mask = '0;
  logic adc_busy = 1'b0;
  logic cpu_halt, t2_halt, t2_rst, adc_off, adc_abort, osc_en, in_idle, in_pdown;
  logic [NP-1:0] pwm_rst, pwm_hold_high;
  logic [NA-1:0] aux_run;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_IRQ(NI), .NUM_PWM(NP), .NUM_AUX(NA)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .pd_enable(pd_enable), .irq_req(irq_req), .irq_mask(irq_mask),
    .adc_busy(adc_busy), .cpu_halt(cpu_halt), .t2_halt(t2_halt),
    .t2_rst(t2_rst), .pwm_rst(pwm_rst), .pwm_hold_high(pwm_hold_high),
    .adc_off(adc_off), .adc_abort(adc_abort), .aux_run(aux_run),
    .osc_en(osc_en), .in_idle(in_idle), .in_pdown(in_pdown)
  );

  // mode: 0 run, 1 idle, 2 power-down
  function automatic logic [VW-1:0] expect_vec(int mode, bit abort);
    bit lp = (mode != 0);
    bit on = (mode != 2);
    return {lp, lp, lp, {NP{lp}}, {NP{lp}}, lp, abort, {NA{on}}, on,
            (mode == 1), (mode == 2)};
  endfunction

  function automatic logic [VW-1:0] observed();
    return {cpu_halt, t2_halt, t2_rst, pwm_rst, pwm_hold_high, adc_off,
            adc_abort, aux_run, osc_en, in_idle, in_pdown};
  endfunction

  task automatic check(string req, logic [VW-1:0] exp);
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, observed(), exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; reg_wr = 1'b0; irq_req = '0;
    repeat (2) @(negedge clk);
    check("R1", expect_vec(0, 1'b0));
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", expect_vec(0, 1'b0));
  endtask

  task automatic write_ctl(logic [1:0] val, bit en);
    reg_wr = 1'b1; reg_wdata = val; pd_enable = en;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    @(negedge clk);
  endtask

  initial begin
    for (int combo = 0; combo < 16; combo++) begin
      for (int irqv = 0; irqv < 256; irqv++) begin
        bit idle_w = combo[0];
        bit pd_w   = combo[1];
        bit en     = combo[2];
        bit busy   = combo[3];
        int mode;
        int m2;
        bit hit;
        string tag;
        if (irqv % 17 != 0 && combo != 1) continue;
        do_reset();
        adc_busy = busy;
        mode = (pd_w && en) ? 2 : (idle_w ? 1 : 0);
        tag = (mode == 2) ? (idle_w ? "R8" : "R4") :
              (mode == 1) ? ((pd_w && !en) ? "R5" : "R2") :
              ((pd_w && !en) ? "R5" : "R2");
        write_ctl({pd_w, idle_w}, en);
        check(tag, expect_vec(mode, (mode != 0) && busy));
        @(negedge clk);
        check("R3", expect_vec(mode, 1'b0));
        // interrupt pattern
        irq_req = irqv[3:0]; irq_mask = irqv[7:4];
        hit = (irqv[3:0] & irqv[7:4]) != 0;
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
        m2 = (mode == 1 && hit) ? 0 : mode;
        check((mode == 2) ? "R7" : "R6", expect_vec(m2, 1'b0));
        // clearing write: idle bit follows, power-down bit must not
        write_ctl(2'b00, 1'b1);
        check("R7", expect_vec((mode == 2) ? 2 : 0, 1'b0));
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule